// File: doc/BRIEF.md
# Software Write Protection Sequencer

This block watches every decoded write strobe on its way to a page write controller and decides whether the strobe's data may be stored. It tracks fixed multi-byte command sequences. A three-byte sequence turns software write protection on. A six-byte sequence turns it off. Every strobe that matches the next step of a sequence is marked as a command byte, and the neighbouring controller does not store it.

When protection is on, an ordinary strobe still reaches the controller, so the write timer still starts. The block drops the commit flag for that strobe, so nothing is stored. The enable sequence also opens an unlock window. The window lets the following byte or page writes commit until the controller reports the end of the write period. A change of the protection state takes effect at that same end-of-period pulse.

The page buffer and the write timer are outside this block. The timer signals through the `wc_done` input.

Top module: `swp_guard`

## Requirements
- R1: After synchronous reset, `commit_ok`, `cmd_mark` and `prot_on` are all low. Protection is off.
- R2: While protection is off, an ordinary strobe gives `commit_ok` high for one cycle. This happens on the cycle after the strobe, and `cmd_mark` stays low.
- R3: The enable sequence has three steps: data AAh at address 1555h, then 55h at 0AAAh, then A0h at 1555h. Each of these strobes gives `cmd_mark` high and `commit_ok` low on the next cycle. `prot_on` rises only on the cycle after the next `wc_done` pulse.
- R4: While protection is on and no unlock window is open, an ordinary strobe gives both `commit_ok` and `cmd_mark` low.
- R5: Completing the enable sequence opens an unlock window, and ordinary strobes commit during it. The window closes at the next `wc_done`, even if no data was written. Strobes after that point are blocked again.
- R6: The disable sequence has six steps. The data values are AAh, 55h, 80h, AAh, 55h, 20h. The addresses alternate 1555h, 0AAAh, 1555h, 1555h, 0AAAh, 1555h. The six strobes are marked as command bytes, and `prot_on` falls on the cycle after the next `wc_done`.
- R7: A strobe that does not match the next expected address and data pair returns the matcher to idle. That strobe is then handled as an ordinary write, and it does not start a new sequence.
- R8: Consecutive strobes of a sequence may be at most `LOAD_WIN` clock cycles apart. With a larger gap the matcher returns to idle, and the late strobe counts as an ordinary write.
- R9: A non-command data value written at 1555h or 0AAAh is an ordinary write, and it commits while protection is off.
- R10: When a strobe and `wc_done` arrive in the same cycle, the strobe is judged against the state after the end of the period. That state has the protection update applied, the window closed and the matcher idle.
- R11: When both an enable and a disable sequence complete before one `wc_done`, the sequence that completed last decides the protection state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_stb | input | 1 | One-cycle decoded write strobe |
| wr_addr | input | AW (13) | Strobe address |
| wr_data | input | 8 | Strobe data |
| wc_done | input | 1 | End-of-write-period pulse from the page write controller |
| commit_ok | output | 1 | Strobe of the previous cycle may be stored |
| cmd_mark | output | 1 | Strobe of the previous cycle was a command byte, suppress it |
| prot_on | output | 1 | Software protection state |

## Verification
The bench checks the block with five kinds of strobe stream:
- Plain data writes with protection off and with protection on. These separate the commit decision from the matcher.
- Complete enable and disable sequences, with and without data writes after them. These show the delayed state change and the closing of the unlock window.
- Broken sequences: a wrong data value, a wrong address, and a gap one cycle longer than the allowed window, set against a gap exactly at the limit. These show that the matcher falls back to idle and does not restart.
- A strobe that lands in the same cycle as `wc_done`.
- An enable sequence followed by a disable sequence inside one write period. These two cases pin down the ordering rules.

// File: rtl/swp_pkg.sv
package swp_pkg;

  // Matcher progress through the shared command prefix and the disable tail.
  typedef enum logic [2:0] {
    M_IDLE = 3'd0,
    M_P1   = 3'd1,
    M_P2   = 3'd2,
    M_D3   = 3'd3,
    M_D4   = 3'd4,
    M_D5   = 3'd5
  } match_st_t;

  localparam logic [7:0] KEY_LEAD   = 8'hAA;
  localparam logic [7:0] KEY_SECOND = 8'h55;
  localparam logic [7:0] KEY_ARM    = 8'hA0;
  localparam logic [7:0] KEY_ERASE  = 8'h80;
  localparam logic [7:0] KEY_DISARM = 8'h20;

endpackage

// File: rtl/swp_seq_match.sv
module swp_seq_match
  import swp_pkg::*;
#(
  parameter int AW       = 13,
  parameter int LOAD_WIN = 16,
  parameter logic [AW-1:0] ADDR_A = 13'h1555,
  parameter logic [AW-1:0] ADDR_B = 13'h0AAA,
  localparam int GW = $clog2(LOAD_WIN + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          stb,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    data,
  input  logic          flush,
  output logic          hit,
  output logic          en_done,
  output logic          dis_done,
  output logic [GW-1:0] gap_o
);

  match_st_t     st_q, st_eff, st_nxt;
  logic [GW-1:0] gap_q;
  logic          at_a, at_b;

  assign at_a  = (addr == ADDR_A);
  assign at_b  = (addr == ADDR_B);
  assign gap_o = gap_q;

  // A write-period end forces the matcher idle before the strobe is judged.
  assign st_eff = flush ? M_IDLE : st_q;

  always_comb begin
    st_nxt   = st_eff;
    hit      = 1'b0;
    en_done  = 1'b0;
    dis_done = 1'b0;
    if (stb) begin
      st_nxt = M_IDLE;
      unique case (st_eff)
        M_IDLE: if (at_a && data == KEY_LEAD) begin
          hit = 1'b1; st_nxt = M_P1;
        end
        M_P1: if (at_b && data == KEY_SECOND) begin
          hit = 1'b1; st_nxt = M_P2;
        end
        M_P2: begin
          if (at_a && data == KEY_ARM) begin
            hit = 1'b1; en_done = 1'b1; st_nxt = M_IDLE;
          end else if (at_a && data == KEY_ERASE) begin
            hit = 1'b1; st_nxt = M_D3;
          end
        end
        M_D3: if (at_a && data == KEY_LEAD) begin
          hit = 1'b1; st_nxt = M_D4;
        end
        M_D4: if (at_b && data == KEY_SECOND) begin
          hit = 1'b1; st_nxt = M_D5;
        end
        M_D5: if (at_a && data == KEY_DISARM) begin
          hit = 1'b1; dis_done = 1'b1; st_nxt = M_IDLE;
        end
        default: st_nxt = M_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= M_IDLE;
      gap_q <= '0;
    end else if (stb) begin
      st_q  <= st_nxt;
      gap_q <= '0;
    end else if (flush) begin
      st_q  <= M_IDLE;
      gap_q <= '0;
    end else if (st_q != M_IDLE) begin
      if (gap_q == GW'(LOAD_WIN - 1)) begin
        st_q  <= M_IDLE;
        gap_q <= '0;
      end else begin
        gap_q <= gap_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/swp_prot_state.sv
module swp_prot_state (
  input  logic clk,
  input  logic rst,
  input  logic flush,
  input  logic en_done,
  input  logic dis_done,
  output logic prot_eff,
  output logic unlock_eff,
  output logic prot_q,
  output logic unlock_q
);

  logic arm_pend_q, disarm_pend_q;

  // State seen by a strobe arriving together with the end of the period.
  always_comb begin
    prot_eff = prot_q;
    if (flush) begin
      if (arm_pend_q)         prot_eff = 1'b1;
      else if (disarm_pend_q) prot_eff = 1'b0;
    end
  end

  assign unlock_eff = flush ? 1'b0 : unlock_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prot_q        <= 1'b0;
      unlock_q      <= 1'b0;
      arm_pend_q    <= 1'b0;
      disarm_pend_q <= 1'b0;
    end else begin
      prot_q <= prot_eff;
      if (en_done) begin
        unlock_q      <= 1'b1;
        arm_pend_q    <= 1'b1;
        disarm_pend_q <= 1'b0;
      end else if (dis_done) begin
        unlock_q      <= unlock_eff;
        arm_pend_q    <= 1'b0;
        disarm_pend_q <= 1'b1;
      end else if (flush) begin
        unlock_q      <= 1'b0;
        arm_pend_q    <= 1'b0;
        disarm_pend_q <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/swp_guard.sv
module swp_guard #(
  parameter int AW       = 13,
  parameter int LOAD_WIN = 16,
  parameter logic [AW-1:0] ADDR_A = 13'h1555,
  parameter logic [AW-1:0] ADDR_B = 13'h0AAA,
  localparam int GW = $clog2(LOAD_WIN + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_stb,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic          wc_done,
  output logic          commit_ok,
  output logic          cmd_mark,
  output logic          prot_on
);

  logic          seq_hit, seq_en, seq_dis;
  logic [GW-1:0] seq_gap;
  logic          prot_eff, unlock_eff, prot_q, unlock_q;
  logic          allow;
  logic          commit_q, cmd_q;

  swp_seq_match #(
    .AW(AW), .LOAD_WIN(LOAD_WIN), .ADDR_A(ADDR_A), .ADDR_B(ADDR_B)
  ) u_match (
    .clk(clk), .rst(rst),
    .stb(wr_stb), .addr(wr_addr), .data(wr_data),
    .flush(wc_done),
    .hit(seq_hit), .en_done(seq_en), .dis_done(seq_dis),
    .gap_o(seq_gap)
  );

  swp_prot_state u_state (
    .clk(clk), .rst(rst),
    .flush(wc_done), .en_done(seq_en), .dis_done(seq_dis),
    .prot_eff(prot_eff), .unlock_eff(unlock_eff),
    .prot_q(prot_q), .unlock_q(unlock_q)
  );

  assign allow = ~prot_eff | unlock_eff;

  always_ff @(posedge clk) begin
    if (rst) begin
      commit_q <= 1'b0;
      cmd_q    <= 1'b0;
    end else begin
      commit_q <= wr_stb & ~seq_hit & allow;
      cmd_q    <= wr_stb & seq_hit;
    end
  end

  assign commit_ok = commit_q;
  assign cmd_mark  = cmd_q;
  assign prot_on   = prot_q;

endmodule

// File: rtl/swp_guard_chk.sv
module swp_guard_chk #(
  parameter int LOAD_WIN = 16,
  localparam int GW = $clog2(LOAD_WIN + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_stb,
  input logic          wc_done,
  input logic          commit_ok,
  input logic          cmd_mark,
  input logic          prot_on,
  input logic          seq_hit,
  input logic          seq_en,
  input logic          unlock_q,
  input logic [GW-1:0] seq_gap
);

  // R2
  excl_flags_chk: assert property (@(posedge clk) disable iff (rst)
    !(commit_ok && cmd_mark));

  // R3
  mark_needs_stb_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_mark |-> $past(wr_stb));

  // R3
  prot_moves_on_done_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(prot_on) |-> $past(wc_done));

  // R4
  locked_no_commit_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && prot_on && !unlock_q && !wc_done && !seq_hit) |=> !commit_ok);

  // R5
  arm_opens_window_chk: assert property (@(posedge clk) disable iff (rst)
    seq_en |=> unlock_q);

  // R8
  gap_bound_chk: assert property (@(posedge clk) disable iff (rst)
    seq_gap < GW'(LOAD_WIN));

endmodule

bind swp_guard swp_guard_chk #(.LOAD_WIN(LOAD_WIN)) u_chk (
  .clk(clk), .rst(rst), .wr_stb(wr_stb), .wc_done(wc_done),
  .commit_ok(commit_ok), .cmd_mark(cmd_mark), .prot_on(prot_on),
  .seq_hit(seq_hit), .seq_en(seq_en), .unlock_q(unlock_q), .seq_gap(seq_gap)
);

// File: tb/tb_swp_guard.sv
module tb_swp_guard;

  localparam int AW  = 13;
  localparam int WIN = 16;
  localparam logic [AW-1:0] A1 = 13'h1555;
  localparam logic [AW-1:0] A2 = 13'h0AAA;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_stb = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0]    wr_data = '0;
  logic          wc_done = 1'b0;
  logic          commit_ok, cmd_mark, prot_on;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // reference model state
  int  m_step = 0;
  int  m_gap = 0;
  bit  m_prot = 0, m_unlock = 0, m_pon = 0, m_poff = 0;
  bit  e_commit = 0, e_cmd = 0;
  logic [AW-1:0] q_addr[6];
  logic [7:0]    q_data[6];

  always #5 clk = ~clk;

  swp_guard #(.AW(AW), .LOAD_WIN(WIN)) dut (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_addr(wr_addr),
    .wr_data(wr_data), .wc_done(wc_done),
    .commit_ok(commit_ok), .cmd_mark(cmd_mark), .prot_on(prot_on)
  );

  task automatic check1(input string tag, input string what, input bit act, input bit exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic model_step(input bit s, input logic [AW-1:0] a, input logic [7:0] d, input bit dn);
    bit ok_step;
    if (dn) begin
      if (m_pon) m_prot = 1;
      else if (m_poff) m_prot = 0;
      m_pon = 0; m_poff = 0; m_unlock = 0; m_step = 0; m_gap = 0;
    end
    e_commit = 0; e_cmd = 0;
    if (s) begin
      ok_step = (a == q_addr[m_step]) && (d == q_data[m_step]);
      if (m_step == 2 && a == A1 && d == 8'hA0) begin
        e_cmd = 1; m_unlock = 1; m_pon = 1; m_poff = 0; m_step = 0;
      end else if (ok_step) begin
        e_cmd = 1;
        if (m_step == 5) begin m_poff = 1; m_pon = 0; m_step = 0; end
        else m_step++;
      end else begin
        m_step = 0;
        e_commit = !m_prot || m_unlock;
      end
      m_gap = 0;
    end else if (!dn && m_step != 0) begin
      m_gap++;
      if (m_gap == WIN) begin m_step = 0; m_gap = 0; end
    end
  endtask

  task automatic tick(input bit s, input logic [AW-1:0] a, input logic [7:0] d,
                      input bit dn, input string tag);
    wr_stb = s; wr_addr = a; wr_data = d; wc_done = dn;
    @(posedge clk);
    model_step(s, a, d, dn);
    @(negedge clk);
    wr_stb = 0; wc_done = 0;
    check1(tag, "commit_ok", commit_ok, e_commit);
    check1(tag, "cmd_mark",  cmd_mark,  e_cmd);
    check1(tag, "prot_on",   prot_on,   m_prot);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d, input string tag);
    tick(1, a, d, 0, tag);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) tick(0, '0, '0, 0, tag);
  endtask

  task automatic done(input string tag);
    tick(0, '0, '0, 1, tag);
  endtask

  task automatic arm(input string tag);
    wr(A1, 8'hAA, tag); wr(A2, 8'h55, tag); wr(A1, 8'hA0, tag);
  endtask

  task automatic disarm(input string tag);
    wr(A1, 8'hAA, tag); wr(A2, 8'h55, tag); wr(A1, 8'h80, tag);
    wr(A1, 8'hAA, tag); wr(A2, 8'h55, tag); wr(A1, 8'h20, tag);
  endtask

  initial begin
    q_addr[0] = A1; q_data[0] = 8'hAA;
    q_addr[1] = A2; q_data[1] = 8'h55;
    q_addr[2] = A1; q_data[2] = 8'h80;
    q_addr[3] = A1; q_data[3] = 8'hAA;
    q_addr[4] = A2; q_data[4] = 8'h55;
    q_addr[5] = A1; q_data[5] = 8'h20;

    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // R1: reset state
    check1("R1", "commit_ok", commit_ok, 1'b0);
    check1("R1", "cmd_mark",  cmd_mark,  1'b0);
    check1("R1", "prot_on",   prot_on,   1'b0);

    // R2: ordinary writes with protection off
    wr(13'h0010, 8'h3C, "R2");
    wr(13'h1FFF, 8'hFF, "R2");
    idle(2, "R2");

    // R9: non-command data at command addresses
    wr(A1, 8'h77, "R9");
    wr(A2, 8'h55, "R9");

    // R7: wrong data then a lone arm byte
    wr(A1, 8'hAA, "R7"); wr(A2, 8'h55, "R7"); wr(A1, 8'h12, "R7");
    wr(A1, 8'hA0, "R7");
    // R7: wrong address at step two
    wr(A1, 8'hAA, "R7"); wr(A1, 8'h55, "R7");
    wr(A2, 8'h55, "R7");

    // R8: gap at the limit continues, one more breaks
    wr(A1, 8'hAA, "R8"); idle(WIN - 1, "R8"); wr(A2, 8'h55, "R8");
    idle(WIN, "R8"); wr(A1, 8'hA0, "R8");
    done("R8");

    // R3: enable, state moves only at period end
    arm("R3");
    idle(3, "R3");
    done("R3");
    idle(1, "R3");

    // R4: protected writes are blocked
    wr(13'h0042, 8'h99, "R4");
    wr(A1, 8'hA0, "R4");
    done("R4");

    // R5: unlocked page writes, then window closes
    arm("R5");
    wr(13'h0100, 8'h01, "R5");
    wr(13'h0101, 8'h02, "R5");
    done("R5");
    wr(13'h0102, 8'h03, "R5");
    arm("R5");
    done("R5");
    wr(13'h0103, 8'h04, "R5");

    // R10: strobe together with period end
    arm("R10");
    tick(1, 13'h0200, 8'h5A, 1, "R10");
    wr(A1, 8'hAA, "R10"); wr(A2, 8'h55, "R10");
    tick(1, A1, 8'hA0, 1, "R10");
    wr(13'h0201, 8'h11, "R10");
    done("R10");

    // R6: disable
    disarm("R6");
    wr(13'h0300, 8'h21, "R6");
    done("R6");
    wr(13'h0301, 8'h22, "R6");

    // R11: enable then disable within one period, and the reverse
    arm("R11"); disarm("R11"); done("R11");
    wr(13'h0400, 8'h31, "R11");
    disarm("R11"); arm("R11"); done("R11");
    wr(13'h0401, 8'h32, "R11");
    done("R11");
    wr(13'h0402, 8'h33, "R11");
    disarm("R11"); done("R11");
    wr(13'h0403, 8'h34, "R11");

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule